// File: doc/BRIEF.md
# Ultrasonic Burst Drive Fault Monitor

This block supervises one transmit burst of an ultrasonic transducer driver. A burst is opened either by a command bit held in a small register file or by activity on two low-voltage drive inputs, chosen by a 2-bit IO mode. While the burst runs, the monitor checks that the drive inputs keep toggling. A timer counts a 1 µs tick input and is cleared by every qualifying edge. A programmable deglitch code sets how long the timer may run before a stuck-drive fault is raised.

The monitor also counts the drive pulses it receives. When the burst closes, it compares that count with a programmed 6-bit burst length. A length of zero means continuous drive, and no count check is made. Both faults are sticky flags in a read-only status byte. Each new burst start clears both flags. A host writes and reads the configuration through a simple address/data port, and it watches the `burst_active` output and the two fault outputs.

Top module: `burst_fault_mon`

## Requirements
- R1: After reset, every configuration field (command bit, IO mode, deglitch code, burst length) reads 0, and `burst_active`, `drv_stuck_flt` and `pulse_cnt_flt` are low.
- R2: Register map. Address 0 bit 0 is the command bit. Address 1 holds the IO mode in bits 1:0 and the deglitch code in bits 4:2. Address 2 holds the burst length in bits 5:0. A write takes effect at the clock edge that samples it. Reads are combinational, and unused bits read 0.
- R3: Address 3 is the status byte. Bit 1 is the stuck-drive fault and bit 2 is the pulse-count fault. All other bits read 0, and writes to address 3 have no effect.
- R4: In IO mode 0, `burst_active` rises one clock after the command bit is written to 1. It falls one clock after the command bit is written to 0.
- R5: In IO modes 1, 2 and 3 the command bit never starts a burst. In IO mode 3 no burst is ever active.
- R6: In IO mode 1, a level change of `io2` starts a burst. In IO mode 2, a level change of `io1` or `io2` starts one. In both modes the burst ends on the 128th tick with no qualifying edge.
- R7: Deglitch codes 0..6 give limits of 64, 48, 32, 24, 16, 8 and 4 ticks. During a burst, the stuck fault is set on tick limit+1 counted since the burst start or the last qualifying edge, and not on tick limit. Code 7 never sets the stuck fault.
- R8: In IO modes 0 and 1, only level changes of `io2` restart the stuck timer. Toggling `io1` does not.
- R9: In IO mode 2, a level change on either input restarts the stuck timer. While both inputs are high, the timer is held at zero.
- R10: Rising edges of `io2` are counted as pulses, and in IO mode 2 rising edges of `io1` are counted as well. This includes an edge in the start cycle. When the burst ends with a nonzero length, the pulse-count fault is set if the count differs from the length.
- R11: A burst length of 0 selects continuous drive. The pulse-count fault is never set for it.
- R12: Both faults stay set after the burst ends. They are cleared only in the cycle in which the next burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data |
| io1 | input | 1 | First drive input |
| io2 | input | 1 | Second drive input |
| tick_us | input | 1 | One-cycle pulse each microsecond |
| burst_active | output | 1 | Burst in progress |
| drv_stuck_flt | output | 1 | Sticky stuck-drive fault |
| pulse_cnt_flt | output | 1 | Sticky pulse-count fault |

## Verification
A wrong stuck timer shows up at the ports as a stuck fault that rises one tick early or late, or never rises. The bench therefore probes tick limit and tick limit+1 for every deglitch code. A wrong pulse counter or a wrong end-of-burst decision shows up within one clock of the burst closing, as a wrong pulse-count flag or a `burst_active` that falls at the wrong time. Flag handling errors show up in the first cycle of the next burst, when both flags must read clear.

// File: rtl/bfm_pkg.sv
package bfm_pkg;

  typedef enum logic [1:0] {
    MODE_CMD  = 2'd0,
    MODE_IO2  = 2'd1,
    MODE_DUAL = 2'd2,
    MODE_OFF  = 2'd3
  } io_mode_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CFG  = 2'd1;
  localparam logic [1:0] A_LEN  = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  localparam logic [2:0] DGL_OFF = 3'd7;

  // stuck limit in microsecond ticks for each deglitch code
  function automatic logic [6:0] dgl_limit(input logic [2:0] code);
    logic [6:0] lim;
    case (code)
      3'd0:    lim = 7'd64;
      3'd1:    lim = 7'd48;
      3'd2:    lim = 7'd32;
      3'd3:    lim = 7'd24;
      3'd4:    lim = 7'd16;
      3'd5:    lim = 7'd8;
      3'd6:    lim = 7'd4;
      default: lim = 7'd0;
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/bfm_regs.sv
module bfm_regs
  import bfm_pkg::*;
#(
  parameter int LEN_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  input  logic              stuck_flt,
  input  logic              pnum_flt,
  output logic [DATA_W-1:0] rd_data,
  output logic              cmd,
  output io_mode_e          mode,
  output logic [2:0]        code,
  output logic [LEN_W-1:0]  len
);

  logic             cmd_d;
  io_mode_e         mode_d;
  logic [2:0]       code_d;
  logic [LEN_W-1:0] len_d;

  always_comb begin
    cmd_d  = cmd;
    mode_d = mode;
    code_d = code;
    len_d  = len;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL: cmd_d = wr_data[0];
        A_CFG: begin
          mode_d = io_mode_e'(wr_data[1:0]);
          code_d = wr_data[4:2];
        end
        A_LEN:  len_d = wr_data[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd  <= 1'b0;
      mode <= MODE_CMD;
      code <= 3'd0;
      len  <= '0;
    end else begin
      cmd  <= cmd_d;
      mode <= mode_d;
      code <= code_d;
      len  <= len_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data[0] = cmd;
      A_CFG:  rd_data[4:0] = {code, mode};
      A_LEN:  rd_data[LEN_W-1:0] = len;
      default: begin
        rd_data[1] = stuck_flt;
        rd_data[2] = pnum_flt;
      end
    endcase
  end

endmodule

// File: rtl/bfm_edge.sv
module bfm_edge
  import bfm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io1,
  input  logic       io2,
  input  io_mode_e   mode,
  output logic       qual_edge,
  output logic [1:0] rise_n,
  output logic       hold
);

  logic io1_q, io2_q;
  logic dual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io1_q <= 1'b0;
      io2_q <= 1'b0;
    end else begin
      io1_q <= io1;
      io2_q <= io2;
    end
  end

  always_comb begin
    dual      = (mode == MODE_DUAL);
    qual_edge = (io2 ^ io2_q) | (dual & (io1 ^ io1_q));
    rise_n    = {1'b0, io2 & ~io2_q} + {1'b0, dual & io1 & ~io1_q};
    hold      = dual & io1 & io2;
  end

endmodule

// File: rtl/bfm_ctrl.sv
module bfm_ctrl
  import bfm_pkg::*;
#(
  parameter int LEN_W    = 6,
  parameter int END_IDLE = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd,
  input  io_mode_e         mode,
  input  logic [2:0]       code,
  input  logic [LEN_W-1:0] len,
  input  logic             tick,
  input  logic             qual_edge,
  input  logic [1:0]       rise_n,
  input  logic             hold,
  output logic             active,
  output logic             stuck_flt,
  output logic             pnum_flt
);

  localparam int TMR_W = $clog2(END_IDLE + 1);
  localparam int CNT_W = LEN_W + 1;
  localparam logic [TMR_W-1:0] END_LAST = TMR_W'(END_IDLE - 1);
  localparam logic [TMR_W-1:0] TMR_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [TMR_W-1:0] timer, timer_d;
  logic [CNT_W-1:0] cnt, cnt_d;
  logic [CNT_W:0]   cnt_sum;
  logic             active_d, stuck_d, pnum_d;
  logic [TMR_W-1:0] lim;
  logic             io_mode, start, stop, quiet_tick, idle_end, stuck_hit;

  always_comb begin
    lim        = TMR_W'(dgl_limit(code));
    io_mode    = (mode == MODE_IO2) || (mode == MODE_DUAL);
    start      = !active && (((mode == MODE_CMD) && cmd) || (io_mode && qual_edge));
    quiet_tick = active && tick && !qual_edge && !hold;
    idle_end   = quiet_tick && (timer == END_LAST);
    stuck_hit  = quiet_tick && (code != DGL_OFF) && (timer == lim);
    case (mode)
      MODE_CMD: stop = active && !cmd;
      MODE_OFF: stop = active;
      default:  stop = idle_end;
    endcase
  end

  // burst state
  always_comb begin
    active_d = active;
    if (start)     active_d = 1'b1;
    else if (stop) active_d = 1'b0;
  end

  // stuck timer
  always_comb begin
    timer_d = timer;
    if (start || !active)                   timer_d = '0;
    else if (qual_edge || hold)             timer_d = '0;
    else if (tick && (timer != TMR_MAX))    timer_d = timer + 1'b1;
  end

  // pulse counter
  always_comb begin
    cnt_sum = {1'b0, cnt} + {{(CNT_W - 1){1'b0}}, rise_n};
    cnt_d   = cnt;
    if (start)
      cnt_d = CNT_W'(rise_n);
    else if (active && (rise_n != 2'd0))
      cnt_d = cnt_sum[CNT_W] ? CNT_MAX : cnt_sum[CNT_W-1:0];
  end

  // sticky fault flags
  always_comb begin
    stuck_d = stuck_flt;
    pnum_d  = pnum_flt;
    if (start) begin
      stuck_d = 1'b0;
      pnum_d  = 1'b0;
    end else begin
      if (stuck_hit) stuck_d = 1'b1;
      if (stop && (len != '0) && (cnt != {1'b0, len})) pnum_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      timer     <= '0;
      cnt       <= '0;
      stuck_flt <= 1'b0;
      pnum_flt  <= 1'b0;
    end else begin
      active    <= active_d;
      timer     <= timer_d;
      cnt       <= cnt_d;
      stuck_flt <= stuck_d;
      pnum_flt  <= pnum_d;
    end
  end

endmodule

// File: rtl/burst_fault_mon.sv
module burst_fault_mon
  import bfm_pkg::*;
#(
  parameter int LEN_W    = 6,
  parameter int END_IDLE = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       io1,
  input  logic       io2,
  input  logic       tick_us,
  output logic       burst_active,
  output logic       drv_stuck_flt,
  output logic       pulse_cnt_flt
);

  logic             rst_m, rst_n_s;
  logic             cfg_cmd;
  io_mode_e         cfg_mode;
  logic [2:0]       cfg_code;
  logic [LEN_W-1:0] cfg_len;
  logic             qual_edge, hold;
  logic [1:0]       rise_n;

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m   <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rst_m   <= 1'b1;
      rst_n_s <= rst_m;
    end
  end

  bfm_regs #(.LEN_W(LEN_W), .DATA_W(8)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .stuck_flt(drv_stuck_flt),
    .pnum_flt(pulse_cnt_flt), .rd_data(rd_data), .cmd(cfg_cmd),
    .mode(cfg_mode), .code(cfg_code), .len(cfg_len)
  );

  bfm_edge u_edge (
    .clk(clk), .rst_n(rst_n_s), .io1(io1), .io2(io2), .mode(cfg_mode),
    .qual_edge(qual_edge), .rise_n(rise_n), .hold(hold)
  );

  bfm_ctrl #(.LEN_W(LEN_W), .END_IDLE(END_IDLE)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .cmd(cfg_cmd), .mode(cfg_mode),
    .code(cfg_code), .len(cfg_len), .tick(tick_us), .qual_edge(qual_edge),
    .rise_n(rise_n), .hold(hold), .active(burst_active),
    .stuck_flt(drv_stuck_flt), .pnum_flt(pulse_cnt_flt)
  );

endmodule

// File: rtl/bfm_checker.sv
module bfm_checker #(
  parameter int LEN_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       rd_addr,
  input logic [7:0]       rd_data,
  input logic [1:0]       mode,
  input logic [2:0]       code,
  input logic [LEN_W-1:0] len,
  input logic             active,
  input logic             stuck,
  input logic             pnum
);

  p_status_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd3) |-> (rd_data == {5'b0, pnum, stuck, 1'b0}));

  p_mode3_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |=> !active);

  p_code7_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stuck) |-> ($past(code) != 3'd7));

  p_stuck_in_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stuck) |-> $past(active));

  p_pnum_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pnum) |-> $fell(active));

  p_continuous_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pnum) |-> ($past(len) != '0));

  p_start_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (!stuck && !pnum));

  p_stuck_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stuck) |-> $rose(active));

  p_pnum_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pnum) |-> $rose(active));

endmodule

bind burst_fault_mon bfm_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .rd_addr(rd_addr), .rd_data(rd_data),
  .mode(cfg_mode), .code(cfg_code), .len(cfg_len), .active(burst_active),
  .stuck(drv_stuck_flt), .pnum(pulse_cnt_flt)
);

// File: tb/sim_burst_fault_mon.sv
`timescale 1ns/1ps
module sim_burst_fault_mon;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  logic       io1, io2, tick_us;
  logic       burst_active, drv_stuck_flt, pulse_cnt_flt;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  localparam int IDLE_END = 128;

  always #4 clk = ~clk;

  burst_fault_mon u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .io1(io1), .io2(io2), .tick_us(tick_us), .burst_active(burst_active),
    .drv_stuck_flt(drv_stuck_flt), .pulse_cnt_flt(pulse_cnt_flt)
  );

  function automatic int lim_of(input int code);
    case (code)
      0: return 64;
      1: return 48;
      2: return 32;
      3: return 24;
      4: return 16;
      5: return 8;
      6: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_pnum(input int len, input int pulses);
    return (len != 0 && pulses != len) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_us = 1'b1;
      step();
      tick_us = 1'b0;
    end
  endtask

  task automatic pulse2();
    io2 = 1'b1; step();
    io2 = 1'b0; step();
  endtask

  task automatic pulse1();
    io1 = 1'b1; step();
    io1 = 1'b0; step();
  endtask

  function automatic logic [7:0] cfg(input int mode, input int code);
    return {3'b0, 3'(code), 2'(mode)};
  endfunction

  task automatic cmd_burst_open(input int code, input int len);
    wr(2'd1, cfg(0, code));
    wr(2'd2, 8'(len));
    wr(2'd0, 8'd1);
    step();
  endtask

  task automatic cmd_burst_close();
    wr(2'd0, 8'd0);
    step();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4470));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    io1 = 1'b0; io2 = 1'b0; tick_us = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    chk("R1 active", int'(burst_active), 0);
    chk("R1 stuck", int'(drv_stuck_flt), 0);
    chk("R1 pnum", int'(pulse_cnt_flt), 0);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a); #1;
      chk("R1 readback", int'(rd_data), 0);
    end

    // R2 register map readback, unused bits zero
    wr(2'd1, 8'hFF); rd_addr = 2'd1; #1;
    chk("R2 cfg", int'(rd_data), 8'h1F);
    wr(2'd2, 8'hFF); rd_addr = 2'd2; #1;
    chk("R2 len", int'(rd_data), 8'h3F);
    wr(2'd1, cfg(1, 7));
    wr(2'd0, 8'hFF); rd_addr = 2'd0; #1;
    chk("R2 ctrl", int'(rd_data), 1);
    // R5 command ignored in mode 1
    step();
    chk("R5 cmd ignored mode1", int'(burst_active), 0);
    wr(2'd1, cfg(2, 7)); step();
    chk("R5 cmd ignored mode2", int'(burst_active), 0);
    wr(2'd1, cfg(3, 7)); pulse2(); pulse1();
    chk("R5 mode3 no burst", int'(burst_active), 0);
    wr(2'd0, 8'd0);

    // R4 mode 0 burst follows the command bit
    wr(2'd1, cfg(0, 7));
    wr(2'd2, 8'd3);
    wr(2'd0, 8'd1);
    chk("R4 not yet active", int'(burst_active), 0);
    step();
    chk("R4 active", int'(burst_active), 1);
    pulse2(); pulse2(); pulse2();
    wr(2'd0, 8'd0);
    chk("R4 still active", int'(burst_active), 1);
    step();
    chk("R4 ended", int'(burst_active), 0);
    chk("R10 exact count", int'(pulse_cnt_flt), 0);

    // R10 short count, R12 sticky then cleared at start
    cmd_burst_open(7, 5);
    pulse2(); pulse2();
    cmd_burst_close();
    chk("R10 short count", int'(pulse_cnt_flt), 1);
    repeat (5) step();
    chk("R12 sticky", int'(pulse_cnt_flt), 1);
    wr(2'd0, 8'd1); step();
    chk("R12 cleared at start", int'(pulse_cnt_flt), 0);
    chk("R12 active", int'(burst_active), 1);
    cmd_burst_close();

    // R11 continuous length
    cmd_burst_open(7, 0);
    pulse2(); pulse2(); pulse2(); pulse2();
    cmd_burst_close();
    chk("R11 continuous", int'(pulse_cnt_flt), 0);

    // R7 each code: limit ticks no fault, limit+1 fault
    for (int c = 0; c < 7; c++) begin
      cmd_burst_open(c, 0);
      ticks(lim_of(c));
      chk("R7 at limit", int'(drv_stuck_flt), 0);
      ticks(1);
      chk("R7 past limit", int'(drv_stuck_flt), 1);
      rd_addr = 2'd3; #1;
      chk("R3 status stuck", int'(rd_data), 8'h02);
      cmd_burst_close();
    end
    // R7 code 7 never faults
    cmd_burst_open(7, 0);
    ticks(100);
    chk("R7 disabled", int'(drv_stuck_flt), 0);
    cmd_burst_close();

    // R8 io1 toggling does not restart timer in mode 0
    cmd_burst_open(5, 0);
    for (int i = 0; i < 9; i++) begin
      io1 = ~io1; step();
      ticks(1);
    end
    chk("R8 io1 ignored mode0", int'(drv_stuck_flt), 1);
    cmd_burst_close();
    io1 = 1'b0; step();
    // R8 io2 edges do restart it
    cmd_burst_open(5, 0);
    for (int i = 0; i < 12; i++) begin
      ticks(6); io2 = ~io2; step();
    end
    chk("R8 io2 restarts", int'(drv_stuck_flt), 0);
    cmd_burst_close();
    io2 = 1'b0; step();

    // R3 status with both flags, writes ignored
    cmd_burst_open(6, 2);
    ticks(5);
    cmd_burst_close();
    wr(2'd3, 8'hFF); rd_addr = 2'd3; #1;
    chk("R3 both flags", int'(rd_data), 8'h06);

    // R6 mode 1 IO start and idle end
    wr(2'd1, cfg(1, 7)); wr(2'd2, 8'd3);
    io2 = 1'b1; step();
    chk("R6 mode1 start", int'(burst_active), 1);
    chk("R12 start clears", int'(drv_stuck_flt), 0);
    io2 = 1'b0; step();
    pulse2(); pulse2();
    ticks(IDLE_END - 1);
    chk("R6 before idle end", int'(burst_active), 1);
    ticks(1);
    chk("R6 idle end", int'(burst_active), 0);
    chk("R10 mode1 count", int'(pulse_cnt_flt), 0);
    // mode 1 stuck timing
    wr(2'd1, cfg(1, 3));
    pulse2();
    ticks(24);
    chk("R7 mode1 limit", int'(drv_stuck_flt), 0);
    ticks(1);
    chk("R7 mode1 fault", int'(drv_stuck_flt), 1);
    ticks(IDLE_END);
    chk("R6 mode1 ended", int'(burst_active), 0);

    // R9/R10 mode 2 counting on both inputs
    wr(2'd1, cfg(2, 7)); wr(2'd2, 8'd4);
    pulse1(); pulse1(); pulse2(); pulse2();
    ticks(IDLE_END);
    chk("R10 dual count ok", int'(pulse_cnt_flt), 0);
    pulse1(); pulse2(); pulse2();
    ticks(IDLE_END);
    chk("R10 dual count short", int'(pulse_cnt_flt), 1);
    // R9 both-high exemption, then io1 edge restarts, then fault
    wr(2'd1, cfg(2, 6));
    io1 = 1'b1; step();
    chk("R6 mode2 io1 start", int'(burst_active), 1);
    io2 = 1'b1; step();
    ticks(20);
    chk("R9 both high exempt", int'(drv_stuck_flt), 0);
    io1 = 1'b0; step();
    ticks(4);
    chk("R9 limit after io1", int'(drv_stuck_flt), 0);
    ticks(1);
    chk("R9 fault", int'(drv_stuck_flt), 1);
    io2 = 1'b0; step();
    ticks(IDLE_END);
    chk("R6 mode2 ended", int'(burst_active), 0);

    // randomized pulse counts in mode 0
    for (int i = 0; i < 16; i++) begin
      int n = $urandom_range(0, 63);
      int k = ($urandom_range(0, 1) == 1) ? n : $urandom_range(0, 70);
      cmd_burst_open(7, n);
      for (int p = 0; p < k; p++) pulse2();
      cmd_burst_close();
      chk("R10 random count", int'(pulse_cnt_flt), exp_pnum(n, k));
      chk("R7 random no stuck", int'(drv_stuck_flt), 0);
    end

    // randomized stuck timing
    for (int i = 0; i < 10; i++) begin
      int c = $urandom_range(0, 6);
      int e = $urandom_range(0, 1);
      cmd_burst_open(c, 0);
      ticks(lim_of(c) + e);
      chk("R7 random stuck", int'(drv_stuck_flt), e);
      cmd_burst_close();
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule